// File: doc/BRIEF.md
# Sensor Sample Register Bank

This block is a read-only register bank for a three-axis motion sensor. It stores the latest 14-bit two's-complement sample of each axis and keeps a ready flag per axis plus one flag that covers every axis at once. A byte-wide serial read front end reaches it through three controls:

- an address load, which starts a read at a given register;
- a read strobe, which returns one byte;
- a stop indication, which ends the burst.

Within one burst the read pointer advances on its own and wraps from the last data byte back to the status byte.

Each axis has a high byte (sample bits 13:6) and a low byte (bits 5:0, left-aligned). The low byte can be read only right after its high byte. When the high byte is read, the block takes a snapshot of the matching low bits. The pair therefore belongs to one sample, even if a new sample is stored between the two reads. An enable input clears all contents while it is low and keeps them while it is high.

Top module: `sensor_regbank`

## Requirements
- R1: Reads return one byte, which appears on `rd_data` in the cycle after the strobe. Address 0 is status. Addresses 1/2 are the X high/low bytes, 3/4 the Y high/low bytes and 5/6 the Z high/low bytes. Address 7 returns 0x00.
- R2: Each strobe advances the pointer 0,1,2,...,6 and then back to 0. A read at address 7 also sends the pointer to 0.
- R3: A stop sets the stored pointer to 0. An address load sets it to `rd_addr`, and a strobe in the same cycle as the load reads at `rd_addr`.
- R4: The status byte carries X ready in bit 0, Y ready in bit 1, Z ready in bit 2 and all-axes ready in bit 3. Bits 7:4 read 0. All flags are 0 after reset.
- R5: A sample strobe sets every per-axis flag. Reading an axis's high byte clears that axis's flag.
- R6: The all-axes flag is set by a sample strobe. It clears only once all three high bytes have been read since that sample.
- R7: The high byte is sample bits 13:6. The low byte is sample bits 5:0 in positions 7:2, and positions 1:0 read 0.
- R8: A low byte read that does not directly follow its own high-byte read returns 0x00. This includes reads after an address load or a stop in between. A snapshot is used at most once.
- R9: The low byte returned after a high byte comes from the same sample as that high byte, even if a new sample was stored in between.
- R10: If a sample strobe and a high-byte read occur in the same cycle, the read returns the old sample and its snapshot holds the old low bits. The axis flag stays 1, and the new sample becomes readable afterwards.
- R11: While `en` is low, the stored samples, flags, pointer, snapshot and `rd_data` are cleared. While `en` is high, the contents are kept indefinitely.
- R12: The extreme codes read as follows: 0x1FFF gives high byte 0x7F and low byte 0xFC, and 0x2000 gives high byte 0x80 and low byte 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low clears all contents synchronously |
| smp_valid | input | 1 | Stores a new sample set this cycle |
| smp_data | input | 42 | Samples {Z, Y, X}, 14 bits each, X in bits 13:0 |
| rd_start | input | 1 | Loads the read pointer from `rd_addr` |
| rd_addr | input | 3 | Start address of a read |
| rd_strobe | input | 1 | Reads one byte at the current address |
| rd_stop | input | 1 | Ends the burst and clears the pointer |
| rd_data | output | 8 | Byte returned by the last strobe |

## Verification
The bench builds the block with its default parameters: three axes, 14-bit samples, byte-wide reads and a 3-bit address. With these values the whole seven-byte map, the wrap from byte 6 to status and the unused address 7 can all be reached in a single burst. The 14-bit width also places both two's-complement extremes on the high/low byte split. The same settings expose the overlaps of a sample with a high-byte read, the repeated address load between a high and a low byte, and the partial read of high bytes that leaves only the all-axes flag set.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    KIND_STATUS = 2'd0,
    KIND_MSB    = 2'd1,
    KIND_LSB    = 2'd2,
    KIND_NONE   = 2'd3
  } reg_kind_e;

  // Next burst address: wraps to status after the last data byte or any
  // address beyond it.
  function automatic int unsigned wrap_step(input int unsigned cur,
                                            input int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/sreg_axis_slot.sv
module sreg_axis_slot #(
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] din,
  input  logic                msb_read,
  output logic [SAMPLE_W-1:0] q,
  output logic                ready
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (!en) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end
  end

  // A new sample beats a clearing read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
    end else if (!en) begin
      ready <= 1'b0;
    end else if (load) begin
      ready <= 1'b1;
    end else if (msb_read) begin
      ready <= 1'b0;
    end
  end

endmodule

// File: rtl/sreg_all_ready.sv
module sreg_all_ready #(
  parameter int unsigned NUM_AXES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                load,
  input  logic [NUM_AXES-1:0] msb_read,
  output logic                all_ready
);

  logic [NUM_AXES-1:0] seen_q;
  logic [NUM_AXES-1:0] seen_nxt;
  logic                every_read;

  assign seen_nxt   = seen_q | msb_read;
  assign every_read = all_ready && (&seen_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_ready <= 1'b0;
      seen_q    <= '0;
    end else if (!en) begin
      all_ready <= 1'b0;
      seen_q    <= '0;
    end else if (load) begin
      all_ready <= 1'b1;
      seen_q    <= '0;
    end else if (every_read) begin
      all_ready <= 1'b0;
      seen_q    <= '0;
    end else if (all_ready) begin
      seen_q    <= seen_nxt;
    end
  end

endmodule

// File: rtl/sreg_read_ptr.sv
module sreg_read_ptr #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned LAST_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              stop,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] ptr_q
);

  logic [ADDR_W-1:0] step;

  assign cur_addr = start ? addr : ptr_q;
  assign step     = ADDR_W'(sreg_pkg::wrap_step(32'(cur_addr), LAST_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (!en) begin
      ptr_q <= '0;
    end else if (stop) begin
      ptr_q <= '0;
    end else if (strobe) begin
      ptr_q <= step;
    end else if (start) begin
      ptr_q <= addr;
    end
  end

endmodule

// File: rtl/sreg_lsb_snap.sv
module sreg_lsb_snap #(
  parameter int unsigned LSB_BITS = 6,
  parameter int unsigned AXIS_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                start,
  input  logic                stop,
  input  logic                strobe,
  input  logic                msb_hit,
  input  logic [AXIS_W-1:0]   msb_axis,
  input  logic [LSB_BITS-1:0] msb_low,
  output logic                snap_valid,
  output logic [AXIS_W-1:0]   snap_axis,
  output logic [LSB_BITS-1:0] snap_bits
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_valid <= 1'b0;
      snap_axis  <= '0;
      snap_bits  <= '0;
    end else if (!en) begin
      snap_valid <= 1'b0;
      snap_axis  <= '0;
      snap_bits  <= '0;
    end else if (stop) begin
      snap_valid <= 1'b0;
    end else if (strobe && msb_hit) begin
      snap_valid <= 1'b1;
      snap_axis  <= msb_axis;
      snap_bits  <= msb_low;
    end else if (strobe || start) begin
      snap_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned NUM_AXES = 3,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         smp_valid,
  input  logic [NUM_AXES*SAMPLE_W-1:0] smp_data,
  input  logic                         rd_start,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic                         rd_strobe,
  input  logic                         rd_stop,
  output logic [BYTE_W-1:0]            rd_data
);
  import sreg_pkg::*;

  localparam int unsigned LSB_BITS  = SAMPLE_W - BYTE_W;
  localparam int unsigned PAD_BITS  = BYTE_W - LSB_BITS;
  localparam int unsigned LAST_ADDR = 2 * NUM_AXES;
  localparam int unsigned AXIS_W    = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1;
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  function automatic logic [BYTE_W-1:0] msb_byte(input logic [SAMPLE_W-1:0] s);
    return s[SAMPLE_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lsb_byte(input logic [LSB_BITS-1:0] b);
    return {b, {PAD_BITS{1'b0}}};
  endfunction

  logic [ADDR_W-1:0]   cur_addr;
  logic [ADDR_W-1:0]   ptr_q;
  reg_kind_e           kind;
  logic [AXIS_W-1:0]   axis;
  logic [SAMPLE_W-1:0] live [NUM_AXES];
  logic [NUM_AXES-1:0] ready;
  logic                all_ready;
  logic [SAMPLE_W-1:0] sel_sample;
  logic                sample_load;
  logic                msb_hit;
  logic                lsb_hit;
  logic                status_hit;
  logic [NUM_AXES-1:0] msb_read_vec;
  logic                snap_valid;
  logic [AXIS_W-1:0]   snap_axis;
  logic [LSB_BITS-1:0] snap_bits;
  logic [BYTE_W-1:0]   byte_nxt;

  assign sample_load = en && smp_valid;

  sreg_read_ptr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .en(en), .start(rd_start), .addr(rd_addr),
    .strobe(rd_strobe), .stop(rd_stop), .cur_addr(cur_addr), .ptr_q(ptr_q)
  );

  // Address decode: odd data addresses are high bytes, even are low bytes.
  always_comb begin
    kind = KIND_NONE;
    axis = '0;
    if (cur_addr == '0) begin
      kind = KIND_STATUS;
    end else if (cur_addr <= LAST_A) begin
      kind = cur_addr[0] ? KIND_MSB : KIND_LSB;
      axis = AXIS_W'((cur_addr - 1'b1) >> 1);
    end
  end

  assign status_hit = rd_strobe && (kind == KIND_STATUS);
  assign msb_hit    = rd_strobe && (kind == KIND_MSB);
  assign lsb_hit    = rd_strobe && (kind == KIND_LSB);

  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
    assign msb_read_vec[k] = msb_hit && (32'(axis) == k);

    sreg_axis_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .en(en), .load(sample_load),
      .din(smp_data[k*SAMPLE_W +: SAMPLE_W]), .msb_read(msb_read_vec[k]),
      .q(live[k]), .ready(ready[k])
    );
  end

  sreg_all_ready #(.NUM_AXES(NUM_AXES)) u_all (
    .clk(clk), .rst_n(rst_n), .en(en), .load(sample_load),
    .msb_read(msb_read_vec), .all_ready(all_ready)
  );

  always_comb begin
    sel_sample = '0;
    for (int k = 0; k < NUM_AXES; k++) begin
      if (32'(axis) == k) sel_sample = live[k];
    end
  end

  sreg_lsb_snap #(.LSB_BITS(LSB_BITS), .AXIS_W(AXIS_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .en(en), .start(rd_start), .stop(rd_stop),
    .strobe(rd_strobe), .msb_hit(msb_hit), .msb_axis(axis),
    .msb_low(sel_sample[LSB_BITS-1:0]), .snap_valid(snap_valid),
    .snap_axis(snap_axis), .snap_bits(snap_bits)
  );

  always_comb begin
    byte_nxt = '0;
    unique case (kind)
      KIND_STATUS: byte_nxt = BYTE_W'({all_ready, ready});
      KIND_MSB:    byte_nxt = msb_byte(sel_sample);
      KIND_LSB:    byte_nxt = (snap_valid && (snap_axis == axis)) ?
                              lsb_byte(snap_bits) : '0;
      default:     byte_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (!en) begin
      rd_data <= '0;
    end else if (rd_strobe) begin
      rd_data <= byte_nxt;
    end
  end

endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned NUM_AXES = 3,
  parameter int unsigned ADDR_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                smp_valid,
  input logic                rd_start,
  input logic                rd_strobe,
  input logic                rd_stop,
  input logic [ADDR_W-1:0]   ptr_q,
  input logic [NUM_AXES-1:0] ready,
  input logic                all_ready,
  input logic [NUM_AXES-1:0] msb_read,
  input logic                status_rd,
  input logic                lsb_rd,
  input logic [BYTE_W-1:0]   rd_data
);
  localparam int unsigned PAD_BITS = BYTE_W - (SAMPLE_W - BYTE_W);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(2 * NUM_AXES);

  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    en && status_rd |=> rd_data[BYTE_W-1:NUM_AXES+1] == '0); // R4

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    en && rd_strobe && !rd_start && !rd_stop && ptr_q == LAST_A |=> ptr_q == '0); // R2

  AST_STOP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    en && rd_stop |=> ptr_q == '0); // R3

  AST_SAMPLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    en && smp_valid |=> (&ready) && all_ready); // R5

  AST_ALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && all_ready && !smp_valid && msb_read == '0 |=> all_ready); // R6

  AST_LSB_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    en && lsb_rd |=> rd_data[PAD_BITS-1:0] == '0); // R7

  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ready == '0 && !all_ready && ptr_q == '0 && rd_data == '0); // R11

  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis_chk
    AST_MSB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      en && msb_read[k] && !smp_valid |=> !ready[k]); // R5
  end

endmodule

bind sensor_regbank sreg_checker #(
  .SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W), .NUM_AXES(NUM_AXES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
  .rd_start(rd_start), .rd_strobe(rd_strobe), .rd_stop(rd_stop),
  .ptr_q(ptr_q), .ready(ready), .all_ready(all_ready),
  .msb_read(msb_read_vec), .status_rd(status_hit), .lsb_rd(lsb_hit),
  .rd_data(rd_data)
);

// File: tb/tb_sensor_regbank.sv
module tb_sensor_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  // Each entry: {Z, Y, X}; status expected right after the sample is stored.
  localparam logic [41:0] VECS [NVEC] = '{
    {14'h0000, 14'h2000, 14'h1FFF},
    {14'h1234, 14'h3FFF, 14'h0001},
    {14'h0FC3, 14'h1555, 14'h2AAA},
    {14'h2001, 14'h003F, 14'h0040}
  };
  localparam logic [7:0] STAT_FULL = 8'h0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        smp_valid = 1'b0;
  logic [41:0] smp_data = '0;
  logic        rd_start = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic        rd_strobe = 1'b0;
  logic        rd_stop = 1'b0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_regbank dut (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
    .smp_data(smp_data), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_strobe(rd_strobe), .rd_stop(rd_stop), .rd_data(rd_data)
  );

  function automatic logic [7:0] hi_of(input logic [13:0] v);
    return 8'(int'(v) / 64);
  endfunction
  function automatic logic [7:0] lo_of(input logic [13:0] v);
    return 8'((int'(v) % 64) * 4);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic push(input logic [41:0] v);
    @(negedge clk); smp_valid = 1'b1; smp_data = v;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic load_addr(input logic [2:0] a);
    @(negedge clk); rd_start = 1'b1; rd_addr = a;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic stop_burst();
    @(negedge clk); rd_stop = 1'b1;
    @(negedge clk); rd_stop = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0; v = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [13:0] ax, ay, az;
    logic [41:0] sa, sb, sc, sd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    check("R4 reset rd_data", rd_data, 8'h00);
    load_addr(3'd0); rd(b); check("R4 reset status", b, 8'h00);
    rd(b); check("R11 reset X high", b, 8'h00);
    stop_burst();

    // Vector table walked by one loop
    for (int i = 0; i < NVEC; i++) begin
      ax = VECS[i][13:0]; ay = VECS[i][27:14]; az = VECS[i][41:28];
      push(VECS[i]);
      load_addr(3'd0);
      rd(b); check("R5 R6 status full", b, STAT_FULL);
      rd(b); check("R1 R7 R12 X high", b, hi_of(ax));
      rd(b); check("R1 R7 R12 X low", b, lo_of(ax));
      rd(b); check("R1 R7 Y high", b, hi_of(ay));
      rd(b); check("R1 R7 R12 Y low", b, lo_of(ay));
      rd(b); check("R1 R7 Z high", b, hi_of(az));
      rd(b); check("R1 R7 Z low", b, lo_of(az));
      rd(b); check("R2 R6 wrap to status cleared", b, 8'h00);
      stop_burst();
    end

    // R8 random low-byte access
    load_addr(3'd2); rd(b); check("R8 direct X low", b, 8'h00);
    stop_burst();
    load_addr(3'd1); rd(b); check("R1 X high again", b, hi_of(VECS[3][13:0]));
    load_addr(3'd2); rd(b); check("R8 low after reload", b, 8'h00);
    stop_burst();

    // R9 coherence across a new sample
    sa = {14'h0A5A, 14'h1111, 14'h0123};
    sb = {14'h3210, 14'h2222, 14'h1ABC};
    push(sa);
    load_addr(3'd1); rd(b); check("R9 X high of A", b, hi_of(sa[13:0]));
    push(sb);
    rd(b); check("R9 X low of A", b, lo_of(sa[13:0]));
    stop_burst();
    load_addr(3'd0); rd(b); check("R5 status after B", b, STAT_FULL);
    rd(b); check("R9 X high of B", b, hi_of(sb[13:0]));
    stop_burst();

    // R10 sample and high-byte read in the same cycle
    sc = {14'h0F0F, 14'h3333, 14'h2468};
    load_addr(3'd1);
    @(negedge clk); smp_valid = 1'b1; smp_data = sc; rd_strobe = 1'b1;
    @(negedge clk); smp_valid = 1'b0; rd_strobe = 1'b0; b = rd_data;
    check("R10 old X high", b, hi_of(sb[13:0]));
    rd(b); check("R10 old X low", b, lo_of(sb[13:0]));
    stop_burst();
    load_addr(3'd0); rd(b); check("R10 flags stay set", b, STAT_FULL);
    rd(b); check("R10 new X high", b, hi_of(sc[13:0]));
    stop_burst();

    // R6 partial high-byte reads
    load_addr(3'd3); rd(b); check("R1 Y high C", b, hi_of(sc[27:14]));
    load_addr(3'd0); rd(b); check("R6 all flag holds", b, 8'h0C);
    load_addr(3'd5); rd(b); check("R1 Z high C", b, hi_of(sc[41:28]));
    load_addr(3'd0); rd(b); check("R6 all flag cleared", b, 8'h00);
    stop_burst();

    // R1 R2 unused address
    load_addr(3'd7); rd(b); check("R1 address 7", b, 8'h00);
    rd(b); check("R2 pointer after 7 is status", b, 8'h00);
    stop_burst();

    // R3 stop clears pointer
    sd = {14'h1357, 14'h0246, 14'h3ACE};
    push(sd);
    load_addr(3'd3); rd(b); check("R3 Y high D", b, hi_of(sd[27:14]));
    stop_burst();
    rd(b); check("R3 stop returns to status", b, 8'h0D);
    rd(b); check("R3 burst continues to X high", b, hi_of(sd[13:0]));
    stop_burst();

    // R11 retention while enabled, clear when disabled
    repeat (50) @(negedge clk);
    load_addr(3'd1); rd(b); check("R11 retained X high", b, hi_of(sd[13:0]));
    stop_burst();
    @(negedge clk); en = 1'b0;
    @(negedge clk); check("R11 rd_data cleared", rd_data, 8'h00); en = 1'b1;
    load_addr(3'd0); rd(b); check("R11 status cleared", b, 8'h00);
    rd(b); check("R11 X high cleared", b, 8'h00);
    rd(b); check("R11 X low cleared", b, 8'h00);
    stop_burst();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule